// File: doc/BRIEF.md
# Floating-Point Store Execution Unit

This unit carries out the floating-point store family of a load/store pipeline. Each request carries a store kind, the two integer register operands (base and index), a 16-bit displacement, a flag saying the base register field was zero, a flag for the update variants, and the 64-bit floating-point source value. From these the unit forms the effective address. It converts or passes through the source value and places it on a big-endian 64-bit memory bus with byte enables.

Requests enter over a valid/ready pair. A request is taken in a cycle where `in_valid` and `in_ready` are both high. The unit holds one memory request in an output register. While that request waits, `in_ready` stays low. This is how back-pressure from the memory port reaches the issuing stage. The memory request stays unchanged until `mem_ready` is seen with `mem_valid`. For update variants, the address writeback to the base register is issued in that same accepting cycle.

A request that is an illegal form, or that would cross a doubleword, produces no memory request and no writeback. Instead, a one-cycle error flag is raised in the cycle after acceptance. The unit changes no status or condition state.

Top module: `fp_store_unit`

## Requirements
- R1: In a non-update request with `in_ra_zero` high, the base is the constant 0; otherwise the base is `in_ra`. The effective address is base plus offset, modulo 2^64.
- R2: Op codes 0 (single, displacement) and 2 (double, displacement) take the offset from `in_disp` sign-extended to 64 bits. Op codes 1 (single, indexed), 3 (double, indexed) and 4 (raw word, indexed) take the offset from `in_rb`.
- R3: An update request (`in_update`=1) always uses `in_ra` as the base. It pulses `wb_valid` with `wb_addr` equal to the effective address exactly in the cycle where `mem_valid` and `mem_ready` are both high. Non-update requests never pulse `wb_valid`.
- R4: An update request with `in_ra_zero`=1 is illegal. It raises `err_illegal` for one cycle after acceptance and produces neither a memory request nor a writeback.
- R5: Single stores (ops 0, 1) write a 4-byte word built from source bit selection, with bit 63 as the most significant. Word bits [31:30] come from source [63:62], and word bits [29:0] come from source [58:29].
- R6: Double stores (ops 2, 3) write all 8 bytes of the source value unchanged.
- R7: Op 4 writes source bits [31:0] as a 4-byte word with no conversion. Op 4 with `in_update`=1, and op codes 5 to 7, are illegal and are handled as in R4.
- R8: Bus lane k (bits [63-8k:56-8k]) holds the byte at address offset k within the doubleword, and `mem_be[k]` enables that lane. The stored value starts at offset `ea[2:0]`, with its most significant byte first.
- R9: A store whose bytes would pass offset 7 raises `err_align` for one cycle after acceptance and produces no memory request or writeback. This means a double with `ea[2:0]`≠0, or a word with `ea[2:0]`>4. When a request is both illegal and misaligned, `err_illegal` alone is raised.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_be` and `mem_data` stay stable and `in_ready` is low. `mem_valid` falls in the cycle after the port accepts.
- R11: After reset `mem_valid`, `wb_valid`, `err_illegal` and `err_align` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_op | input | 3 | Store kind (codes per R2, R7) |
| in_update | input | 1 | Update variant: write address back to base register |
| in_ra_zero | input | 1 | Base register field is zero |
| in_ra | input | 64 | Base register value |
| in_rb | input | 64 | Index register value |
| in_disp | input | 16 | Displacement |
| in_fpr | input | 64 | Floating-point source value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory port accepts |
| mem_addr | output | 64 | Effective address |
| mem_be | output | 8 | Byte enables, bit k for offset k |
| mem_data | output | 64 | Big-endian write data lanes |
| wb_valid | output | 1 | Base register writeback strobe |
| wb_addr | output | 64 | Value written back to the base register |
| err_illegal | output | 1 | Illegal-form pulse |
| err_align | output | 1 | Doubleword-crossing pulse |

## Verification
Random requests mix all eight op codes with random update and zero-base flags. They cover both negative and positive displacements and addresses whose low three bits land everywhere in the doubleword. Together these separate the addressing variants from each other, and the legal placements from the crossing ones. Directed cases use a known double (1.0 becomes 0x3F800000) to expose any wrong bit selection. A raw-word case with distinct halves shows which half is stored. A zero-base case with a nonzero register value shows whether the constant zero is used. Random stall lengths on the memory port test whether the request holds steady and whether the writeback waits for acceptance.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam logic [2:0] OP_SGL_D  = 3'd0;
  localparam logic [2:0] OP_SGL_X  = 3'd1;
  localparam logic [2:0] OP_DBL_D  = 3'd2;
  localparam logic [2:0] OP_DBL_X  = 3'd3;
  localparam logic [2:0] OP_RAWW_X = 3'd4;

  typedef enum logic [1:0] {FMT_SINGLE, FMT_DOUBLE, FMT_RAW} fpst_fmt_e;

  typedef struct packed {
    logic      legal_op;
    logic      indexed;
    fpst_fmt_e fmt;
  } fpst_dec_t;

  function automatic fpst_dec_t fpst_decode(input logic [2:0] op);
    fpst_dec_t d;
    d.legal_op = 1'b1;
    d.indexed  = 1'b0;
    d.fmt      = FMT_SINGLE;
    case (op)
      OP_SGL_D:  ;
      OP_SGL_X:  d.indexed = 1'b1;
      OP_DBL_D:  d.fmt = FMT_DOUBLE;
      OP_DBL_X:  begin d.indexed = 1'b1; d.fmt = FMT_DOUBLE; end
      OP_RAWW_X: begin d.indexed = 1'b1; d.fmt = FMT_RAW; end
      default:   d.legal_op = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/fpst_addr_gen.sv
module fpst_addr_gen
  import fpst_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16
) (
  input  fpst_dec_t          dec,
  input  logic               update,
  input  logic               ra_zero,
  input  logic [XLEN-1:0]    ra,
  input  logic [XLEN-1:0]    rb,
  input  logic [DISP_W-1:0]  disp,
  output logic [XLEN-1:0]    ea,
  output logic               illegal
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] base, offset;

  always_comb begin
    base    = (update || !ra_zero) ? ra : '0;
    offset  = dec.indexed ? rb : {{EXT_W{disp[DISP_W-1]}}, disp};
    ea      = base + offset;
    illegal = !dec.legal_op
            || (update && ra_zero)
            || (update && dec.fmt == FMT_RAW);
  end
endmodule

// File: rtl/fpst_data_fmt.sv
module fpst_data_fmt
  import fpst_pkg::*;
#(
  parameter int BUS_BYTES = 8
) (
  input  fpst_fmt_e                     fmt,
  input  logic [8*BUS_BYTES-1:0]        src,
  input  logic [$clog2(BUS_BYTES)-1:0]  ofs,
  output logic [BUS_BYTES-1:0]          be,
  output logic [8*BUS_BYTES-1:0]        lanes,
  output logic                          misalign
);
  localparam int DW     = 8 * BUS_BYTES;
  localparam int HALF   = DW / 2;
  localparam int WORD_B = BUS_BYTES / 2;

  logic [31:0]            sgl_word;
  logic [DW-1:0]          payload;
  logic [BUS_BYTES-1:0]   mask;
  logic [2*BUS_BYTES-1:0] mask_wide;

  always_comb begin
    // bit selection; valid for normals, zero, infinity and NaN
    sgl_word = {src[DW-1 -: 2], src[DW-6 -: 30]};
    case (fmt)
      FMT_DOUBLE: begin payload = src;                               mask = '1; end
      FMT_RAW:    begin payload = {src[HALF-1:0], {HALF{1'b0}}};     mask = {{WORD_B{1'b0}}, {WORD_B{1'b1}}}; end
      default:    begin payload = {sgl_word, {(DW-32){1'b0}}};       mask = {{WORD_B{1'b0}}, {WORD_B{1'b1}}}; end
    endcase
  end

  // place each lane: lane k receives payload byte (k - ofs)
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    always_comb begin
      if (k >= int'(ofs))
        lanes[DW-1-8*k -: 8] = payload[DW-1-8*(k-int'(ofs)) -: 8];
      else
        lanes[DW-1-8*k -: 8] = 8'h00;
    end
  end

  always_comb begin
    mask_wide = {{BUS_BYTES{1'b0}}, mask} << ofs;
    be        = mask_wide[BUS_BYTES-1:0];
    misalign  = |mask_wide[2*BUS_BYTES-1:BUS_BYTES];
  end
endmodule

// File: rtl/fp_store_unit.sv
module fp_store_unit
  import fpst_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int DISP_W    = 16,
  parameter int BUS_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2:0]             in_op,
  input  logic                   in_update,
  input  logic                   in_ra_zero,
  input  logic [XLEN-1:0]        in_ra,
  input  logic [XLEN-1:0]        in_rb,
  input  logic [DISP_W-1:0]      in_disp,
  input  logic [8*BUS_BYTES-1:0] in_fpr,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic [XLEN-1:0]        mem_addr,
  output logic [BUS_BYTES-1:0]   mem_be,
  output logic [8*BUS_BYTES-1:0] mem_data,
  output logic                   wb_valid,
  output logic [XLEN-1:0]        wb_addr,
  output logic                   err_illegal,
  output logic                   err_align
);
  localparam int DW    = 8 * BUS_BYTES;
  localparam int OFS_W = $clog2(BUS_BYTES);

  fpst_dec_t            dec;
  logic [XLEN-1:0]      ea;
  logic                 illegal, misalign;
  logic [BUS_BYTES-1:0] be_c;
  logic [DW-1:0]        lanes_c;
  logic                 upd_q;
  logic                 accept, mem_fire;

  assign dec = fpst_decode(in_op);

  fpst_addr_gen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_addr (
    .dec(dec), .update(in_update), .ra_zero(in_ra_zero),
    .ra(in_ra), .rb(in_rb), .disp(in_disp),
    .ea(ea), .illegal(illegal)
  );

  fpst_data_fmt #(.BUS_BYTES(BUS_BYTES)) u_fmt (
    .fmt(dec.fmt), .src(in_fpr), .ofs(ea[OFS_W-1:0]),
    .be(be_c), .lanes(lanes_c), .misalign(misalign)
  );

  assign in_ready = !mem_valid;
  assign accept   = in_valid && in_ready;
  assign mem_fire = mem_valid && mem_ready;
  assign wb_valid = mem_fire && upd_q;
  assign wb_addr  = mem_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      mem_be      <= '0;
      mem_data    <= '0;
      upd_q       <= 1'b0;
      err_illegal <= 1'b0;
      err_align   <= 1'b0;
    end else begin
      err_illegal <= 1'b0;
      err_align   <= 1'b0;
      if (mem_fire) mem_valid <= 1'b0;
      if (accept) begin
        if (illegal)       err_illegal <= 1'b1;
        else if (misalign) err_align   <= 1'b1;
        else begin
          mem_valid <= 1'b1;
          mem_addr  <= ea;
          mem_be    <= be_c;
          mem_data  <= lanes_c;
          upd_q     <= in_update;
        end
      end
    end
  end

  // R10: request held steady under back-pressure
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_data));
  // R4, R7: illegal form leaves no memory request
  p_illegal_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> !mem_valid && !wb_valid && !err_align);
  // R9: crossing store leaves no memory request
  p_align_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> !mem_valid && !wb_valid);
  // R8: only word or doubleword enables reach the bus
  p_be_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 4 || $countones(mem_be) == BUS_BYTES));
  // R3: writeback only during a memory handshake
  p_wb_on_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mem_valid && mem_ready);
  // R10: a taken request drops valid next cycle
  p_fire_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid);
endmodule

// File: tb/fp_store_unit_test.sv
module fp_store_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [2:0]  in_op;
  logic        in_update, in_ra_zero;
  logic [63:0] in_ra, in_rb, in_fpr;
  logic [15:0] in_disp;
  logic        mem_valid, mem_ready;
  logic [63:0] mem_addr, mem_data, wb_addr;
  logic [7:0]  mem_be;
  logic        wb_valid, err_illegal, err_align;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_store_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_update(in_update), .in_ra_zero(in_ra_zero),
    .in_ra(in_ra), .in_rb(in_rb), .in_disp(in_disp), .in_fpr(in_fpr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_data(mem_data), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .err_illegal(err_illegal), .err_align(err_align)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent reference built from the requirement text
  task automatic model(input logic [2:0] op, input logic upd, input logic raz,
                       input logic [63:0] ra, input logic [63:0] rb,
                       input logic [15:0] disp, input logic [63:0] fpr,
                       output logic [63:0] ea, output logic ill, output logic mis,
                       output logic [7:0] be, output logic [63:0] data);
    logic [63:0] b, o;
    logic [31:0] w;
    int nbytes, a;
    logic [7:0] bytes [8];
    b   = (!upd && raz) ? 64'd0 : ra;
    o   = (op == 3'd0 || op == 3'd2) ? {{48{disp[15]}}, disp} : rb;
    ea  = b + o;
    ill = (op > 3'd4) || (upd && raz) || (upd && op == 3'd4);
    w = 32'h0;
    for (int i = 0; i < 32; i++) begin
      if (i >= 30) w[i] = fpr[i + 32];
      else         w[i] = fpr[i + 29];
    end
    if (op == 3'd4) w = fpr[31:0];
    nbytes = (op == 3'd2 || op == 3'd3) ? 8 : 4;
    for (int i = 0; i < 8; i++) begin
      if (nbytes == 8) bytes[i] = fpr[63 - 8*i -: 8];
      else if (i < 4)  bytes[i] = w[31 - 8*i -: 8];
      else             bytes[i] = 8'h00;
    end
    a    = int'(ea[2:0]);
    mis  = (a + nbytes) > 8;
    be   = 8'h00;
    data = 64'h0;
    for (int k = 0; k < 8; k++) begin
      if (k >= a && k < a + nbytes) begin
        be[k] = 1'b1;
        data[63 - 8*k -: 8] = bytes[k - a];
      end
    end
  endtask

  task automatic do_req(input logic [2:0] op, input logic upd, input logic raz,
                        input logic [63:0] ra, input logic [63:0] rb,
                        input logic [15:0] disp, input logic [63:0] fpr,
                        input int stall);
    logic [63:0] ea, data;
    logic ill, mis;
    logic [7:0] be;
    model(op, upd, raz, ra, rb, disp, fpr, ea, ill, mis, be, data);
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", "in_ready idle", {63'd0, in_ready}, 64'd1);
    in_valid = 1'b1; in_op = op; in_update = upd; in_ra_zero = raz;
    in_ra = ra; in_rb = rb; in_disp = disp; in_fpr = fpr;
    @(negedge clk);
    in_valid = 1'b0;
    if (ill) begin
      chk(err_illegal == 1'b1 && mem_valid == 1'b0, "R4", "illegal flag",
          {62'd0, err_illegal, mem_valid}, 64'd2);
    end else if (mis) begin
      chk(err_align == 1'b1 && mem_valid == 1'b0 && err_illegal == 1'b0, "R9",
          "align flag", {61'd0, err_align, mem_valid, err_illegal}, 64'd4);
    end else begin
      chk(mem_valid == 1'b1, "R10", "mem_valid", {63'd0, mem_valid}, 64'd1);
      for (int s = 0; s <= stall; s++) begin
        chk(mem_addr == ea, (op == 3'd0 || op == 3'd2) ? "R2" : "R1", "addr", mem_addr, ea);
        chk(mem_be == be, "R8", "byte enables", {56'd0, mem_be}, {56'd0, be});
        chk(mem_data == data, (op == 3'd2 || op == 3'd3) ? "R6" : (op == 3'd4 ? "R7" : "R5"),
            "data", mem_data, data);
        chk(in_ready == 1'b0 && wb_valid == 1'b0, "R10", "busy and no early writeback",
            {62'd0, in_ready, wb_valid}, 64'd0);
        if (s < stall) @(negedge clk);
      end
      mem_ready = 1'b1;
      #1;
      chk(wb_valid == upd, "R3", "writeback strobe", {63'd0, wb_valid}, {63'd0, upd});
      if (upd) chk(wb_addr == ea, "R3", "writeback value", wb_addr, ea);
      @(negedge clk);
      mem_ready = 1'b0;
      chk(mem_valid == 1'b0, "R10", "valid drops after accept", {63'd0, mem_valid}, 64'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 3'd0; in_update = 1'b0;
    in_ra_zero = 1'b0; in_ra = '0; in_rb = '0; in_disp = '0; in_fpr = '0;
    mem_ready = 1'b0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_valid && !wb_valid && !err_illegal && !err_align && in_ready, "R11",
        "reset state", {59'd0, mem_valid, wb_valid, err_illegal, err_align, in_ready}, 64'd1);

    // R5: 1.0 double converts to 0x3F800000
    do_req(3'd0, 1'b0, 1'b0, 64'h1000, 64'h0, 16'h0008, 64'h3FF0_0000_0000_0000, 0);
    chk(mem_data == 64'h3F80_0000_0000_0000 || mem_valid, "R5", "1.0 as single",
        mem_data, 64'h3F80_0000_0000_0000);
    // R1: zero base selects constant
    do_req(3'd1, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0000, 64'h2000, 16'h0, 64'h4000_0000_0000_0000, 2);
    // R2: negative displacement
    do_req(3'd2, 1'b0, 1'b0, 64'h1_0000, 64'h0, 16'hFFF8, 64'h0123_4567_89AB_CDEF, 1);
    // R7: raw low word at offset 4
    do_req(3'd4, 1'b0, 1'b0, 64'h3000, 64'h4, 16'h0, 64'hAAAA_BBBB_1234_5678, 0);
    // R3: update with stall
    do_req(3'd3, 1'b1, 1'b0, 64'h8000, 64'h40, 16'h0, 64'hFEDC_BA98_7654_3210, 3);
    // R4: update with zero base
    do_req(3'd2, 1'b1, 1'b1, 64'h8000, 64'h0, 16'h0010, 64'h1, 0);
    // R7: raw with update, and undefined code
    do_req(3'd4, 1'b1, 1'b0, 64'h8000, 64'h8, 16'h0, 64'h1, 0);
    do_req(3'd6, 1'b0, 1'b0, 64'h8000, 64'h8, 16'h0, 64'h1, 0);
    // R9: crossing double and word, legal word at offset 4
    do_req(3'd3, 1'b0, 1'b0, 64'h8000, 64'h4, 16'h0, 64'h1, 0);
    do_req(3'd1, 1'b0, 1'b0, 64'h8000, 64'h5, 16'h0, 64'h1, 0);
    do_req(3'd1, 1'b0, 1'b0, 64'h8000, 64'h4, 16'h0, 64'h3FF0_0000_0000_0000, 0);

    for (int n = 0; n < N_RANDOM; n++) begin
      logic [2:0] op;
      logic [63:0] ra, rb, fpr;
      op  = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
      ra  = {$urandom(), $urandom()};
      rb  = {$urandom(), $urandom()};
      fpr = {$urandom(), $urandom()};
      if ($urandom_range(0, 1) == 1) begin ra[2:0] = 3'd0; rb[2:0] = 3'($urandom_range(0, 1) * 4); end
      do_req(op, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0),
             ra, rb, 16'($urandom()), fpr, $urandom_range(0, 3));
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule